// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable slave for a two-wire serial bus that stands in for a 256-byte, byte-wide non-volatile memory. It runs on a fast system clock, oversamples the SCL and SDA lines, and pulls SDA low through an open-drain enable. A bus master addresses it with a device byte, then either sets a word address and streams data into a page buffer, or reads bytes from a shared address counter.

Writes land in an 8-byte page buffer and are committed to the storage array when the master sends STOP. A timed busy window then follows. While that window runs, the slave does not acknowledge its device address, so the master can poll until the write has finished. Reads come in three forms, all served by one address counter: current-address, random (a dummy write of the word address followed by a repeated START) and sequential. A write-protect input blocks updates to the array.

Top module: `twi_eeprom`

## Requirements
- R1: After reset, `sda_oe_o` is low, the storage array reads back 0xFF in every byte, and the address counter is 0, so a current-address read returns the byte at address 0.
- R2: A device byte is accepted only when bits 7:4 equal 4'b1010 and bits 3:1 equal `dev_sel_i`. Bit 0 is 1 for a read and 0 for a write. Any other device byte gets no acknowledge, and the slave then ignores the bus until the next START.
- R3: Each byte that is accepted is acknowledged by holding SDA low for the whole ninth SCL pulse. The slave changes `sda_oe_o` only while SCL is low.
- R4: After a write device byte, the next byte sets the word address. Each data byte after it goes into the page buffer at the low 3 address bits, and only those 3 bits advance, so a ninth or later byte wraps to the start of the same 8-byte page. STOP commits every buffered byte to the array at once.
- R5: A commit starts a busy window of `WRITE_CYCLES` system clocks. During the window the slave does not acknowledge its device byte. After the window it acknowledges again.
- R6: A random read (write device byte, word address, repeated START, read device byte) returns the byte at that word address.
- R7: The address counter holds the last accessed address plus one. A current-address read returns the byte there.
- R8: In a sequential read, every master acknowledge yields the next byte, and the counter wraps from 255 to 0. A master NACK followed by STOP ends the read.
- R9: While `wp_i` is high at STOP, data bytes are still acknowledged, but the array keeps its old contents and no busy window starts.
- R10: A START or STOP in the middle of a byte abandons the current transfer. A START leads straight into device-address matching. A STOP given before any complete data byte commits nothing and starts no busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | High pulls SDA low |
| wp_i | input | 1 | Write protect, high blocks array updates |
| dev_sel_i | input | 3 | Strapped device select bits matched against device byte bits 3:1 |

## Verification
A wrong internal state shows up at the ports within one byte time. A bad device-match or busy state shows as a missing or extra acknowledge on the ninth clock of the next device byte. A wrong address counter or page offset shows as a wrong data bit on the next read. Write-protect faults and commit faults only show on a later read-back, so every write is followed by a read of the bytes it touched and of one neighbouring byte. Busy-window faults are caught by polling twice: once right after STOP and once after the window has run out.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} state_e;
  typedef enum logic [1:0] {K_DEV, K_WADDR, K_DATA} kind_e;
  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/twi_eeprom_cond.sv
module twi_eeprom_cond #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC-1:0] scl_sync_q, sda_sync_q;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[SYNC-2:0], scl_i};
      sda_sync_q <= {sda_sync_q[SYNC-2:0], sda_i};
      scl_q      <= scl_o;
      sda_q      <= sda_o;
    end
  end

  assign scl_o      = scl_sync_q[SYNC-1];
  assign sda_o      = sda_sync_q[SYNC-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edges count as conditions only while SCL stays high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/twi_eeprom_mem.sv
module twi_eeprom_mem #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int PAGE   = 1 << PAGE_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [7:0]                 rd_data_o,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-PAGE_W-1:0]   wr_page_i,
  input  logic [PAGE-1:0]            wr_mask_i,
  input  logic [PAGE-1:0][7:0]       wr_data_i
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= 8'hFF;
    end else if (wr_en_i) begin
      for (int i = 0; i < PAGE; i++)
        if (wr_mask_i[i]) mem_q[{wr_page_i, PAGE_W'(i)}] <= wr_data_i[i];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/twi_eeprom_fsm.sv
module twi_eeprom_fsm
  import twi_eeprom_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int PAGE_W       = 3,
  parameter int WRITE_CYCLES = 5000,
  localparam int PAGE        = 1 << PAGE_W,
  localparam int CNT_W       = $clog2(WRITE_CYCLES + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     scl_i,
  input  logic                     sda_i,
  input  logic                     scl_rise_i,
  input  logic                     scl_fall_i,
  input  logic                     start_i,
  input  logic                     stop_i,
  input  logic                     wp_i,
  input  logic [2:0]               dev_sel_i,
  input  logic [7:0]               rd_data_i,
  output logic [ADDR_W-1:0]        rd_addr_o,
  output logic                     wr_en_o,
  output logic [ADDR_W-PAGE_W-1:0] wr_page_o,
  output logic [PAGE-1:0]          wr_mask_o,
  output logic [PAGE-1:0][7:0]     wr_data_o,
  output logic                     sda_oe_o
);
  state_e                 state_q;
  kind_e                  kind_q;
  logic [3:0]             bit_cnt_q;
  logic [7:0]             sh_q;
  logic                   rw_q, mack_q;
  logic [ADDR_W-1:0]      addr_q;
  logic [PAGE-1:0][7:0]   pbuf_q;
  logic [PAGE-1:0]        mask_q;
  logic [CNT_W-1:0]       busy_cnt_q;
  logic                   busy, commit;

  assign busy   = busy_cnt_q != '0;
  assign commit = stop_i && (mask_q != '0) && !wp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      kind_q     <= K_DEV;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b0;
      addr_q     <= '0;
      pbuf_q     <= '0;
      mask_q     <= '0;
      busy_cnt_q <= '0;
    end else begin
      if (busy) busy_cnt_q <= busy_cnt_q - 1'b1;
      if (stop_i) begin
        state_q <= ST_IDLE;
        mask_q  <= '0;
        if (commit) busy_cnt_q <= CNT_W'(WRITE_CYCLES);
      end else if (start_i) begin
        state_q   <= ST_RX;
        kind_q    <= K_DEV;
        bit_cnt_q <= '0;
        mask_q    <= '0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise_i) begin
              sh_q      <= {sh_q[6:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
              bit_cnt_q <= '0;
              unique case (kind_q)
                K_DEV: begin
                  if (sh_q[7:4] == DEV_CODE && sh_q[3:1] == dev_sel_i && !busy) begin
                    state_q <= ST_ACK;
                    rw_q    <= sh_q[0];
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                K_WADDR: begin
                  addr_q  <= sh_q;
                  state_q <= ST_ACK;
                end
                default: begin
                  pbuf_q[addr_q[PAGE_W-1:0]] <= sh_q;
                  mask_q[addr_q[PAGE_W-1:0]] <= 1'b1;
                  addr_q[PAGE_W-1:0]         <= addr_q[PAGE_W-1:0] + PAGE_W'(1);
                  state_q                    <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              bit_cnt_q <= '0;
              if (kind_q == K_DEV && rw_q) begin
                state_q <= ST_TX;
                sh_q    <= rd_data_i;
                addr_q  <= addr_q + 1'b1;
              end else begin
                state_q <= ST_RX;
                if (kind_q == K_DEV) kind_q <= K_WADDR;
                else                 kind_q <= K_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i) begin
              if (bit_cnt_q == 4'd8) state_q <= ST_MACK;
              else                   sh_q    <= {sh_q[6:0], 1'b0};
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                state_q   <= ST_TX;
                sh_q      <= rd_data_i;
                addr_q    <= addr_q + 1'b1;
                bit_cnt_q <= '0;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr_o = addr_q;
  assign wr_en_o   = commit;
  assign wr_page_o = addr_q[ADDR_W-1:PAGE_W];
  assign wr_mask_o = mask_q;
  assign wr_data_o = pbuf_q;
  assign sda_oe_o  = (state_q == ST_ACK) || (state_q == ST_TX && !sh_q[7]);

  a_r3_oe_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);
  a_r4_page_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q == K_DATA && $past(kind_q == K_DATA) && !$past(start_i))
      |-> $stable(addr_q[ADDR_W-1:PAGE_W]));
  a_r5_busy_no_dev_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !(state_q == ST_ACK && kind_q == K_DEV));
  a_r9_wp_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(!wp_i));
  a_r10_start_rematch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> (state_q == ST_RX && kind_q == K_DEV && bit_cnt_q == 4'd0));
endmodule

// File: rtl/twi_eeprom.sv
module twi_eeprom #(
  parameter int ADDR_W       = 8,
  parameter int PAGE_W       = 3,
  parameter int SYNC         = 2,
  parameter int WRITE_CYCLES = 5000,
  localparam int PAGE        = 1 << PAGE_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       wp_i,
  input  logic [2:0] dev_sel_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic [ADDR_W-1:0]        rd_addr;
  logic [7:0]               rd_data;
  logic                     wr_en;
  logic [ADDR_W-PAGE_W-1:0] wr_page;
  logic [PAGE-1:0]          wr_mask;
  logic [PAGE-1:0][7:0]     wr_data;

  twi_eeprom_cond #(.SYNC(SYNC)) u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  twi_eeprom_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)) u_fsm (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop),
    .wp_i, .dev_sel_i, .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .wr_en_o(wr_en), .wr_page_o(wr_page), .wr_mask_o(wr_mask), .wr_data_o(wr_data),
    .sda_oe_o
  );

  twi_eeprom_mem #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_mem (
    .clk_i, .rst_ni, .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_page_i(wr_page), .wr_mask_i(wr_mask), .wr_data_i(wr_data)
  );
endmodule

// File: tb/tb_twi_eeprom.sv
module tb_twi_eeprom;
  localparam int WC = 300;
  localparam int Q  = 8;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0, rst_ni = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  twi_eeprom #(.WRITE_CYCLES(WC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .wp_i(wp), .dev_sel_i(SEL)
  );

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  int model [256];
  int maddr = 0;
  logic [7:0] wq [$];

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wt(Q); scl_m = 1'b1; wt(Q); scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q / 2);
    ack = ~sda_line;
    wt(Q / 2); scl_m = 1'b0; wt(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl_m = 1'b1; wt(Q / 2); b[i] = sda_line; wt(Q / 2); scl_m = 1'b0;
    end
    sda_m = ~mack; wt(Q); scl_m = 1'b1; wt(Q); scl_m = 1'b0; wt(2); sda_m = 1'b1;
  endtask

  task automatic write_q(input logic [7:0] addr, input string tag);
    logic ack;
    bus_start();
    send_byte({4'b1010, SEL, 1'b0}, ack); chk({tag, " dev ack"}, ack, 1);
    send_byte(addr, ack);                 chk({tag, " addr ack"}, ack, 1);
    foreach (wq[i]) begin
      send_byte(wq[i], ack);              chk({tag, " data ack"}, ack, 1);
      if (!wp) model[{addr[7:3], 3'(addr[2:0] + i)}] = wq[i];
    end
    bus_stop();
    maddr = {addr[7:3], 3'(int'(addr[2:0]) + wq.size())};
  endtask

  task automatic poll(input int exp, input string tag);
    logic ack;
    bus_start();
    send_byte({4'b1010, SEL, 1'b0}, ack);
    chk(tag, ack, exp);
    bus_stop();
  endtask

  task automatic read_n(input int addr, input int n, input string tag);
    logic ack;
    logic [7:0] b;
    bus_start();
    if (addr >= 0) begin
      send_byte({4'b1010, SEL, 1'b0}, ack); chk({tag, " dummy dev ack"}, ack, 1);
      send_byte(8'(addr), ack);             chk({tag, " dummy addr ack"}, ack, 1);
      bus_start();
      maddr = addr;
    end
    send_byte({4'b1010, SEL, 1'b1}, ack);   chk({tag, " read dev ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk({tag, " data"}, b, model[maddr]);
      maddr = (maddr + 1) % 256;
    end
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ack;
    for (int a = 0; a < 256; a++) model[a] = 8'hFF;
    wt(5);
    chk("R1 oe in reset", sda_oe, 0);
    rst_ni = 1'b1; wt(4);
    chk("R1 oe after reset", sda_oe, 0);
    read_n(-1, 1, "R1 current read at 0");
    read_n(8'h10, 2, "R6 R1 erased random read");

    // R2 mismatches
    bus_start(); send_byte({4'b1010, SEL ^ 3'b001, 1'b0}, ack); chk("R2 wrong select", ack, 0); bus_stop();
    bus_start(); send_byte({4'b1011, SEL, 1'b0}, ack);          chk("R2 wrong code", ack, 0);   bus_stop();

    // R4 byte write, R5 polling
    wq = '{8'h5A};
    write_q(8'h20, "R4 byte write");
    poll(0, "R5 nack while busy");
    wt(WC + 50);
    poll(1, "R5 ack after window");
    read_n(8'h20, 1, "R6 random read");
    read_n(-1, 1, "R7 current read after random");

    // R4 page wrap: 10 bytes from offset 5
    wq = {};
    for (int i = 0; i < 10; i++) wq.push_back(8'(8'h30 + i));
    write_q(8'h45, "R4 page wrap write");
    wt(WC + 50);
    read_n(8'h40, 9, "R8 R4 sequential over page");
    read_n(8'h44, 1, "R6 page read");
    read_n(-1, 2, "R7 current after page read");

    // R8 wrap from 255 to 0
    wq = '{8'hA5}; write_q(8'hFF, "R8 setup top"); wt(WC + 50);
    wq = '{8'h3C}; write_q(8'h00, "R8 setup bottom"); wt(WC + 50);
    read_n(8'hFE, 3, "R8 counter wrap");

    // R9 write protect
    wp = 1'b1;
    wq = '{8'h11, 8'h22};
    write_q(8'h20, "R9 protected write");
    poll(1, "R9 no busy window");
    wp = 1'b0;
    read_n(8'h20, 2, "R9 array unchanged");

    // R10 start mid-byte, then full write
    bus_start(); send_bits({4'b1010, SEL, 1'b0}, 4);
    wq = '{8'h77};
    write_q(8'h30, "R10 write after abort");
    wt(WC + 50);
    read_n(8'h30, 1, "R10 data after abort");

    // R10 stop mid word-address byte
    bus_start(); send_byte({4'b1010, SEL, 1'b0}, ack); chk("R10 dev ack", ack, 1);
    send_bits(8'h55, 4); bus_stop();
    poll(1, "R10 stop mid-byte no busy");
    read_n(8'h55, 1, "R10 unchanged");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule